// File: doc/BRIEF.md
# CPU Clock Ratio Divider

This block slows a processor core relative to its root clock without gating that clock. It drives a one-cycle clock-enable pulse at the start of every output period. The core's registers advance only on cycles where the enable is high. The period is 1, 2, 3 or 4 root cycles, and software selects it with a single write strobe carrying a 2-bit ratio code. After reset the core runs undivided, so the enable is high on every cycle.

Ratio changes are meant to be rare. The block treats them as a static setting with a lockout window. Once a new ratio is accepted, every further change request is silently dropped until the window has run out. A write that repeats the ratio already programmed is not a change, so it is never accepted and never restarts the window. An accepted ratio does not take effect at once. It waits for the end of the period that is in progress, so no period is ever cut short. The readback port shows the ratio in effect at that moment, not the one waiting to take effect.

Top module: `clk_ratio_div`

## Requirements
- R1: During and right after a synchronous reset, `ratio_active` is 2'b00 and `clk_en` is 1.
- R2: The ratio code selects the period: 2'b00 gives 1 root cycle, 2'b01 gives 2, 2'b10 gives 3 and 2'b11 gives 4. While a code is in effect, `clk_en` is high for exactly one cycle per period, and successive pulses are exactly that many cycles apart.
- R3: A write (`cfg_wr` high) counts as a change request only when `cfg_ratio` differs from the last accepted ratio. A write of the same value does nothing and does not restart the lockout window.
- R4: After a change is accepted on a clock edge, change requests on the following LOCK_CYC-1 edges (15 with defaults) are ignored. A request on edge LOCK_CYC after the accepted one is accepted. Each accepted change restarts the window.
- R5: A request ignored during the lockout window has no later effect: the ratio it carried never becomes active.
- R6: An accepted ratio becomes active only on the edge that ends the current output period. `clk_en` is high in the first cycle of the new ratio, and the old period is never shortened.
- R7: `ratio_active` shows the ratio currently in effect. It keeps its old value while an accepted change is still waiting for the period boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Root clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Ratio write strobe, one cycle per write |
| cfg_ratio | input | RATIO_W (2) | Requested ratio code |
| clk_en | output | 1 | Registered core clock enable, one pulse per period |
| ratio_active | output | RATIO_W (2) | Ratio code currently in effect |

## Verification
The bench builds the block with its default parameters: a 2-bit ratio code, so periods of 1 to 4 cycles, and a 16-cycle lockout. This keeps the whole lockout window short enough to cross many times in a few thousand cycles. With these values, random writes often land inside the window, and some land on its last ignored edge or its first open edge. Directed sequences place a request exactly on edge 15 and on edge 16 after an acceptance. They also check that a repeated same-value write does not extend the window, and that a change made just after a divide-by-4 pulse waits out the full period.

// File: rtl/crd_pkg.sv
package crd_pkg;
  // Default code width: periods 1 .. 2**CRD_RATIO_W root cycles
  parameter int CRD_RATIO_W  = 2;
  // Default lockout length in root cycles after an accepted change
  parameter int CRD_LOCK_CYC = 16;
endpackage

// File: rtl/crd_lockout.sv
// Down-counter that blocks ratio change requests after an acceptance.
module crd_lockout #(
  parameter int LOCK_CYC = crd_pkg::CRD_LOCK_CYC
) (
  input  logic clk,
  input  logic rst,
  input  logic accept_i,
  output logic busy_o
);
  localparam int LW = $clog2(LOCK_CYC + 1);
  localparam logic [LW-1:0] LOAD = LW'(LOCK_CYC - 1);

  logic [LW-1:0] remain_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      remain_q <= '0;
    end else if (accept_i) begin
      remain_q <= LOAD;
    end else if (remain_q != '0) begin
      remain_q <= remain_q - 1'b1;
    end
  end

  assign busy_o = (remain_q != '0);
endmodule

// File: rtl/crd_setting.sv
// Holds the programmed ratio and decides whether a write is accepted.
module crd_setting #(
  parameter int RATIO_W = crd_pkg::CRD_RATIO_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_i,
  input  logic [RATIO_W-1:0] wr_val_i,
  input  logic               busy_i,
  output logic               accept_o,
  output logic [RATIO_W-1:0] target_o
);
  logic [RATIO_W-1:0] target_q;

  assign accept_o = wr_i && (wr_val_i != target_q) && !busy_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      target_q <= '0;
    end else if (accept_o) begin
      target_q <= wr_val_i;
    end
  end

  assign target_o = target_q;
endmodule

// File: rtl/crd_phase.sv
// Period counter; swaps in the programmed ratio only at a period boundary.
module crd_phase #(
  parameter int RATIO_W = crd_pkg::CRD_RATIO_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [RATIO_W-1:0] target_i,
  output logic               en_o,
  output logic [RATIO_W-1:0] active_o
);
  logic [RATIO_W-1:0] phase_q;
  logic [RATIO_W-1:0] active_q;
  logic               en_q;
  logic               last_phase;

  // The code value equals the index of the last phase of the period
  assign last_phase = (phase_q == active_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q  <= '0;
      active_q <= '0;
      en_q     <= 1'b1;
    end else if (last_phase) begin
      phase_q  <= '0;
      active_q <= target_i;
      en_q     <= 1'b1;
    end else begin
      phase_q  <= phase_q + 1'b1;
      en_q     <= 1'b0;
    end
  end

  assign en_o     = en_q;
  assign active_o = active_q;
endmodule

// File: rtl/clk_ratio_div.sv
module clk_ratio_div #(
  parameter int RATIO_W  = crd_pkg::CRD_RATIO_W,
  parameter int LOCK_CYC = crd_pkg::CRD_LOCK_CYC
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_wr,
  input  logic [RATIO_W-1:0] cfg_ratio,
  output logic               clk_en,
  output logic [RATIO_W-1:0] ratio_active
);
  logic               accept;
  logic               busy;
  logic [RATIO_W-1:0] target;

  crd_lockout #(.LOCK_CYC(LOCK_CYC)) u_lockout (
    .clk      (clk),
    .rst      (rst),
    .accept_i (accept),
    .busy_o   (busy)
  );

  crd_setting #(.RATIO_W(RATIO_W)) u_setting (
    .clk      (clk),
    .rst      (rst),
    .wr_i     (cfg_wr),
    .wr_val_i (cfg_ratio),
    .busy_i   (busy),
    .accept_o (accept),
    .target_o (target)
  );

  crd_phase #(.RATIO_W(RATIO_W)) u_phase (
    .clk      (clk),
    .rst      (rst),
    .target_i (target),
    .en_o     (clk_en),
    .active_o (ratio_active)
  );
endmodule

// File: rtl/crd_checker.sv
module crd_checker #(
  parameter int RATIO_W  = crd_pkg::CRD_RATIO_W,
  parameter int LOCK_CYC = crd_pkg::CRD_LOCK_CYC
) (
  input logic               clk,
  input logic               rst,
  input logic               clk_en,
  input logic [RATIO_W-1:0] ratio_active
);
  localparam int GW = RATIO_W + 1;
  localparam int SW = $clog2(LOCK_CYC + 2);
  localparam int MIN_APART = LOCK_CYC - (1 << RATIO_W);

  logic [GW-1:0]      gap_q;
  logic [RATIO_W-1:0] per_ratio_q;
  logic               started_q;
  logic [RATIO_W-1:0] prev_act_q;
  logic [SW-1:0]      since_q;
  logic               seen_chg_q;
  logic               chg;

  assign chg = (ratio_active != prev_act_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      gap_q       <= '0;
      per_ratio_q <= '0;
      started_q   <= 1'b0;
      prev_act_q  <= '0;
      since_q     <= '0;
      seen_chg_q  <= 1'b0;
    end else begin
      prev_act_q <= ratio_active;
      if (clk_en) begin
        gap_q       <= '0;
        per_ratio_q <= ratio_active;
        started_q   <= 1'b1;
      end else if (gap_q != '1) begin
        gap_q <= gap_q + 1'b1;
      end
      if (chg) begin
        since_q    <= SW'(1);
        seen_chg_q <= 1'b1;
      end else if (since_q < SW'(LOCK_CYC)) begin
        since_q <= since_q + 1'b1;
      end
    end
  end

  // R1
  a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (clk_en && ratio_active == '0));

  // R2
  a_r2_pulse_spacing: assert property (@(posedge clk) disable iff (rst)
    (clk_en && started_q) |-> (gap_q == GW'(per_ratio_q)));

  // R2
  a_r2_undivided_every_cycle: assert property (@(posedge clk) disable iff (rst)
    (ratio_active == '0) |-> clk_en);

  // R6
  a_r6_switch_at_boundary: assert property (@(posedge clk) disable iff (rst)
    !$stable(ratio_active) |-> clk_en);

  // R4
  a_r4_changes_spread: assert property (@(posedge clk) disable iff (rst)
    (chg && seen_chg_q) |-> (int'(since_q) >= MIN_APART));
endmodule

bind clk_ratio_div crd_checker #(.RATIO_W(RATIO_W), .LOCK_CYC(LOCK_CYC)) u_crd_checker (
  .clk          (clk),
  .rst          (rst),
  .clk_en       (clk_en),
  .ratio_active (ratio_active)
);

// File: tb/test_clk_ratio_div.sv
`timescale 1ns/1ps
module test_clk_ratio_div;
  localparam int RW   = 2;
  localparam int LOCK = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_wr = 1'b0;
  logic [RW-1:0] cfg_ratio = '0;
  logic          clk_en;
  logic [RW-1:0] ratio_active;

  int n_chk = 0;
  int n_bad = 0;

  // Reference state, derived from the requirements
  logic [RW-1:0] m_req, m_act;
  int            m_ph, m_lock;
  logic          m_en;

  always #2.5 clk = ~clk;

  clk_ratio_div #(.RATIO_W(RW), .LOCK_CYC(LOCK)) i_clk_ratio_div (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_ratio(cfg_ratio),
    .clk_en(clk_en), .ratio_active(ratio_active)
  );

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Advance one edge: update the reference, then compare away from the edge
  task automatic step();
    logic acc, wrap;
    @(posedge clk);
    acc  = cfg_wr && (cfg_ratio != m_req) && (m_lock == 0);
    wrap = (m_ph == int'(m_act));
    m_en = wrap;
    if (wrap) begin m_ph = 0; m_act = m_req; end
    else m_ph++;
    if (acc) begin m_req = cfg_ratio; m_lock = LOCK - 1; end
    else if (m_lock > 0) m_lock--;
    @(negedge clk);
    check("R2", int'(clk_en), int'(m_en));
    check("R7", int'(ratio_active), int'(m_act));
    cfg_wr = 1'b0;
  endtask

  task automatic wr_step(logic [RW-1:0] v);
    cfg_wr = 1'b1;
    cfg_ratio = v;
    step();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    #1000000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int gap;
    void'($urandom(32'd4242));
    m_req = '0; m_act = '0; m_ph = 0; m_lock = 0; m_en = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", int'(ratio_active), 0);
    check("R1", int'(clk_en), 1);
    rst = 1'b0;
    step();
    check("R1", int'(clk_en), 1);

    // R4: edge 15 after acceptance ignored, edge 16 accepted
    wr_step(2'b01);
    idle(14);
    wr_step(2'b11);
    check("R4", int'(ratio_active), 1);
    wr_step(2'b10);
    idle(6);
    check("R4", int'(ratio_active), 2);

    // R3: same-value write must not restart the window
    idle(20);
    wr_step(2'b10);
    wr_step(2'b11);
    idle(8);
    check("R3", int'(ratio_active), 3);

    // R5: write dropped inside the window never takes effect
    idle(2);
    wr_step(2'b00);
    idle(20);
    check("R5", int'(ratio_active), 3);

    // R6/R7: change just after a divide-by-4 pulse waits the whole period
    while (clk_en !== 1'b1) step();
    wr_step(2'b01);
    check("R7", int'(ratio_active), 3);
    gap = 1;
    while (clk_en !== 1'b1 && gap < 10) begin step(); gap++; end
    check("R6", gap, 4);
    check("R6", int'(ratio_active), 1);
    idle(1);
    check("R2", int'(clk_en), 0);
    idle(1);
    check("R2", int'(clk_en), 1);

    // Random writes, checked every cycle against the reference
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(7) == 0) wr_step(RW'($urandom_range(3)));
      else step();
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule